// File: doc/BRIEF.md
# Two-Cell Protection Switch Controller

This block is the digital decision core of a protector for a pack of two lithium cells in series. Comparators and timers elsewhere reduce the analog world to single-bit flags: each cell is under its discharge floor or over its charge ceiling (the over-charge flag arrives already qualified by its own delay), the whole pack is below its undervoltage limit, a charger is present, a load is attached, the discharge current has tripped, the load has been taken away, and the centre-tap connection is open. From these flags the controller picks one operating mode. It then drives a single enable for the pair of back-to-back low-side switches and a request that puts the rest of the chip into low-power shutdown.

Two modes charge a weak pack through a duty-cycled switch. A free-running 3-bit slot counter advances on a one-clock pulse that arrives every 4 ms. With a cell over-discharged and a charger attached, the switch is on for 7 slots in 8. With the pack in undervoltage and a charger attached, it is on for 1 slot in 8. In the off slots a probe strobe asks the analog side to check that the charger is still connected.

The over-current fault is latched. The block powers up in shutdown and leaves it only when a charger appears.

Top module: `cellpair_guard`

## Requirements
- R1: While reset is asserted and in the first cycle after it, switch_en is 0, shutdown_req is 1 and probe_stb is 0.
- R2: While shutdown_req is 1, every input other than charger_in is ignored. The cycle after charger_in is seen at 1, the block leaves shutdown and selects a mode from the current flags.
- R3: With both cells in the normal zone, the tap connected, the pack not undervoltage and no latched over-current, switch_en is 1 whether or not charger_in is set.
- R4: If either cell is over-discharged, or the pack is undervoltage, and charger_in is 0 (and no higher-priority condition holds), then switch_en goes to 0 and shutdown_req goes to 1.
- R5: If either cell is over-discharged and charger_in is 1, switch_en is 1 in slots 0 to 6 and 0 in slot 7.
- R6: If the pack is undervoltage and charger_in is 1, switch_en is 1 only in slot 0.
- R7: A pulse on overcurrent forces switch_en to 0. It stays 0 until load_clear is seen with overcurrent low.
- R8: While tap_open is 1, switch_en is 0, except when pack_low and charger_in are both 1. In that case the 1-in-8 charging of R6 applies.
- R9: With a cell over-charged, switch_en is 1 only when charger_in is 0 and load_in is 1. Otherwise it is 0.
- R10: When several conditions hold at once, they are resolved in this order: latched over-current, then open tap, then pack undervoltage, then cell over-discharge, then cell over-charge, then normal.
- R11: The slot number advances by one on each tick_4ms pulse and wraps from 7 to 0. It returns to 0 in the cycle in which the mode changes.
- R12: probe_stb is 1 exactly in the off slots of the 7/8 and 1/8 modes, and 0 in every other mode.
- R13: All outputs are registered. A change in the inputs shows at the outputs after exactly one rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_4ms | input | 1 | One-clock pulse every 4 ms; advances the slot |
| lo_cell_under | input | 1 | Lower cell below its discharge floor |
| hi_cell_under | input | 1 | Upper cell below its discharge floor |
| lo_cell_over | input | 1 | Lower cell above its charge ceiling (delay-qualified) |
| hi_cell_over | input | 1 | Upper cell above its charge ceiling (delay-qualified) |
| pack_low | input | 1 | Whole pack below its undervoltage limit |
| charger_in | input | 1 | Charger detected |
| load_in | input | 1 | Load attached |
| overcurrent | input | 1 | Discharge current trip |
| load_clear | input | 1 | Load removed after a trip |
| tap_open | input | 1 | Centre-tap connection lost |
| switch_en | output | 1 | Enable for the back-to-back low-side switches |
| shutdown_req | output | 1 | Request for low-power shutdown |
| probe_stb | output | 1 | Charger re-check strobe during off slots |

## Verification
A wrong mode register shows at the next rising edge as the wrong switch level or the wrong shutdown request. The only exception is a wrong choice between the 7/8 and 1/8 modes, which look the same in slot 0. That case appears within one tick, because slot 1 is on in one mode and off in the other. A slot counter that fails to clear on a mode change shows at once in the first slot of the new mode. A missing wrap or a miscount shows by the eighth tick at the latest, as an off slot in the wrong position. A lost over-current latch shows the first cycle after the trip pulse ends, when the switch comes back on without load_clear.

// File: rtl/cpg_pkg.sv
package cpg_pkg;

    typedef enum logic [2:0] {
        MD_SHDN = 3'd0,
        MD_NORM = 3'd1,
        MD_OVC  = 3'd2,
        MD_DEEP = 3'd3,
        MD_UVCH = 3'd4,
        MD_TRIP = 3'd5,
        MD_TAP  = 3'd6
    } cpg_mode_e;

    typedef struct packed {
        logic lo_under;
        logic hi_under;
        logic lo_over;
        logic hi_over;
        logic pack_low;
        logic charger;
        logic load;
        logic tap_open;
    } cpg_flags_t;

endpackage

// File: rtl/cpg_mode_sel.sv
module cpg_mode_sel
    import cpg_pkg::*;
(
    input  cpg_mode_e  mode_q,
    input  logic       trip_q,
    input  cpg_flags_t flags,
    input  logic       overcurrent,
    input  logic       load_clear,
    output cpg_mode_e  mode_d,
    output logic       trip_d
);
    logic any_under;
    logic any_over;

    always_comb begin
        any_under = flags.lo_under | flags.hi_under;
        any_over  = flags.lo_over  | flags.hi_over;
        trip_d    = 1'b0;
        mode_d    = MD_NORM;
        if ((mode_q == MD_SHDN) && !flags.charger) begin
            // shutdown: only the charger flag is looked at
            mode_d = MD_SHDN;
            trip_d = 1'b0;
        end else begin
            trip_d = overcurrent | (trip_q & ~load_clear);
            if (trip_d) begin
                mode_d = MD_TRIP;
            end else if (flags.tap_open) begin
                mode_d = (flags.pack_low && flags.charger) ? MD_UVCH : MD_TAP;
            end else if (flags.pack_low) begin
                mode_d = flags.charger ? MD_UVCH : MD_SHDN;
            end else if (any_under) begin
                mode_d = flags.charger ? MD_DEEP : MD_SHDN;
            end else if (any_over) begin
                mode_d = MD_OVC;
            end else begin
                mode_d = MD_NORM;
            end
        end
    end

endmodule

// File: rtl/cpg_slot_next.sv
module cpg_slot_next
    import cpg_pkg::*;
#(
    parameter int SLOT_W = 3
) (
    input  cpg_mode_e         mode_q,
    input  cpg_mode_e         mode_d,
    input  logic              tick,
    input  logic [SLOT_W-1:0] slot_q,
    output logic [SLOT_W-1:0] slot_d
);
    localparam logic [SLOT_W-1:0] SLOT_ONE = SLOT_W'(1);

    always_comb begin
        if (mode_d != mode_q) begin
            slot_d = '0;
        end else if (tick) begin
            slot_d = slot_q + SLOT_ONE;
        end else begin
            slot_d = slot_q;
        end
    end

endmodule

// File: rtl/cpg_duty_gen.sv
module cpg_duty_gen
    import cpg_pkg::*;
#(
    parameter int SLOT_W         = 3,
    parameter int DEEP_OFF_SLOTS = 1,
    parameter int UV_ON_SLOTS    = 1
) (
    input  cpg_mode_e         mode,
    input  logic [SLOT_W-1:0] slot,
    input  logic              charger,
    input  logic              load,
    output logic              sw_on,
    output logic              probe
);
    localparam int SLOTS = 1 << SLOT_W;
    localparam logic [SLOT_W:0] DEEP_LIM = (SLOT_W + 1)'(SLOTS - DEEP_OFF_SLOTS);
    localparam logic [SLOT_W:0] UV_LIM   = (SLOT_W + 1)'(UV_ON_SLOTS);

    logic [SLOT_W:0] slot_x;
    logic            duty_mode;

    always_comb begin
        slot_x    = {1'b0, slot};
        duty_mode = (mode == MD_DEEP) || (mode == MD_UVCH);
        unique case (mode)
            MD_NORM: sw_on = 1'b1;
            MD_OVC:  sw_on = !charger && load;
            MD_DEEP: sw_on = slot_x < DEEP_LIM;
            MD_UVCH: sw_on = slot_x < UV_LIM;
            default: sw_on = 1'b0;
        endcase
        probe = duty_mode && !sw_on;
    end

endmodule

// File: rtl/cellpair_guard.sv
module cellpair_guard
    import cpg_pkg::*;
#(
    parameter int SLOT_W         = 3,
    parameter int DEEP_OFF_SLOTS = 1,
    parameter int UV_ON_SLOTS    = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_4ms,
    input  logic lo_cell_under,
    input  logic hi_cell_under,
    input  logic lo_cell_over,
    input  logic hi_cell_over,
    input  logic pack_low,
    input  logic charger_in,
    input  logic load_in,
    input  logic overcurrent,
    input  logic load_clear,
    input  logic tap_open,
    output logic switch_en,
    output logic shutdown_req,
    output logic probe_stb
);
    typedef struct packed {
        cpg_mode_e         mode;
        logic [SLOT_W-1:0] slot;
        logic              trip;
        logic              sw;
        logic              shdn;
        logic              probe;
    } guard_state_t;

    guard_state_t st_q, st_d;
    cpg_flags_t   flags;
    cpg_mode_e    mode_d;
    logic         trip_d;
    logic [SLOT_W-1:0] slot_d;
    logic         sw_d;
    logic         probe_d;

    assign flags = '{lo_under: lo_cell_under, hi_under: hi_cell_under,
                     lo_over: lo_cell_over, hi_over: hi_cell_over,
                     pack_low: pack_low, charger: charger_in,
                     load: load_in, tap_open: tap_open};

    cpg_mode_sel u_mode_sel (
        .mode_q      (st_q.mode),
        .trip_q      (st_q.trip),
        .flags       (flags),
        .overcurrent (overcurrent),
        .load_clear  (load_clear),
        .mode_d      (mode_d),
        .trip_d      (trip_d)
    );

    cpg_slot_next #(.SLOT_W(SLOT_W)) u_slot_next (
        .mode_q (st_q.mode),
        .mode_d (mode_d),
        .tick   (tick_4ms),
        .slot_q (st_q.slot),
        .slot_d (slot_d)
    );

    cpg_duty_gen #(
        .SLOT_W         (SLOT_W),
        .DEEP_OFF_SLOTS (DEEP_OFF_SLOTS),
        .UV_ON_SLOTS    (UV_ON_SLOTS)
    ) u_duty_gen (
        .mode    (mode_d),
        .slot    (slot_d),
        .charger (charger_in),
        .load    (load_in),
        .sw_on   (sw_d),
        .probe   (probe_d)
    );

    always_comb begin
        st_d       = st_q;
        st_d.mode  = mode_d;
        st_d.slot  = slot_d;
        st_d.trip  = trip_d;
        st_d.sw    = sw_d;
        st_d.probe = probe_d;
        st_d.shdn  = (mode_d == MD_SHDN);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{mode: MD_SHDN, slot: '0, trip: 1'b0,
                      sw: 1'b0, shdn: 1'b1, probe: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign switch_en    = st_q.sw;
    assign shutdown_req = st_q.shdn;
    assign probe_stb    = st_q.probe;

endmodule

// File: rtl/cpg_checker.sv
module cpg_checker (
    input logic clk,
    input logic rst_n,
    input logic lo_cell_under,
    input logic hi_cell_under,
    input logic pack_low,
    input logic charger_in,
    input logic overcurrent,
    input logic tap_open,
    input logic switch_en,
    input logic shutdown_req,
    input logic probe_stb
);
    // R1
    off_in_shutdown_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown_req |-> !switch_en);

    // R2
    shutdown_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (shutdown_req && !charger_in) |=> shutdown_req);

    // R4
    deep_nochg_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((lo_cell_under || hi_cell_under) && !charger_in) |=> !switch_en);

    // R7
    trip_forces_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overcurrent |=> !switch_en);

    // R8
    tap_open_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tap_open && !(pack_low && charger_in)) |=> !switch_en);

    // R12
    probe_only_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        probe_stb |-> (!switch_en && !shutdown_req));

endmodule

bind cellpair_guard cpg_checker u_cpg_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .lo_cell_under (lo_cell_under),
    .hi_cell_under (hi_cell_under),
    .pack_low      (pack_low),
    .charger_in    (charger_in),
    .overcurrent   (overcurrent),
    .tap_open      (tap_open),
    .switch_en     (switch_en),
    .shutdown_req  (shutdown_req),
    .probe_stb     (probe_stb)
);

// File: tb/cellpair_guard_bench.sv
module cellpair_guard_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick_4ms = 1'b0;
    logic lo_cell_under = 1'b0, hi_cell_under = 1'b0;
    logic lo_cell_over = 1'b0, hi_cell_over = 1'b0;
    logic pack_low = 1'b0, charger_in = 1'b0, load_in = 1'b0;
    logic overcurrent = 1'b0, load_clear = 1'b0, tap_open = 1'b0;
    logic switch_en, shutdown_req, probe_stb;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    cellpair_guard u_cellpair_guard (
        .clk(clk), .rst_n(rst_n), .tick_4ms(tick_4ms),
        .lo_cell_under(lo_cell_under), .hi_cell_under(hi_cell_under),
        .lo_cell_over(lo_cell_over), .hi_cell_over(hi_cell_over),
        .pack_low(pack_low), .charger_in(charger_in), .load_in(load_in),
        .overcurrent(overcurrent), .load_clear(load_clear), .tap_open(tap_open),
        .switch_en(switch_en), .shutdown_req(shutdown_req), .probe_stb(probe_stb)
    );

    // input order: charger, load, overcurrent, load_clear, tap, pack_low,
    //              hi_under, lo_under, hi_over, lo_over ; then expected sw, shdn, probe
    localparam int NVEC = 23;
    localparam logic [12:0] VEC [NVEC] = '{
        13'b0000000000_010,  // 0  R2 stay in shutdown
        13'b0110111111_010,  // 1  R2 everything but charger ignored
        13'b1000000000_100,  // 2  R2 charger exits, R3 normal
        13'b0100000000_100,  // 3  R3 no charger still on
        13'b0100000010_100,  // 4  R9 overcharge, load, no charger
        13'b1100000010_000,  // 5  R9 overcharge with charger
        13'b0000000001_000,  // 6  R9 overcharge, no load
        13'b0100000000_100,  // 7  R3
        13'b0110000000_000,  // 8  R7 trip
        13'b0100000000_000,  // 9  R7 latched
        13'b0101000000_100,  // 10 R7 load cleared
        13'b0100100000_000,  // 11 R8 tap open
        13'b1000110000_100,  // 12 R8 exception, 1/8 slot 0
        13'b1000000100_100,  // 13 R5 7/8 slot 0
        13'b1010000100_000,  // 14 R10 trip beats deep discharge
        13'b1001000100_100,  // 15 R7 clear, back to 7/8
        13'b0000001000_010,  // 16 R4 deep discharge no charger
        13'b0100000000_010,  // 17 R2 held
        13'b1000010000_100,  // 18 R6 undervoltage with charger
        13'b0000010000_010,  // 19 R4 undervoltage no charger
        13'b1000000000_100,  // 20 R2 exit
        13'b0000100100_000,  // 21 R10 tap beats deep discharge
        13'b1000000000_100   // 22 R3
    };

    task automatic set_inputs(input logic [9:0] v);
        {charger_in, load_in, overcurrent, load_clear, tap_open, pack_low,
         hi_cell_under, lo_cell_under, hi_cell_over, lo_cell_over} = v;
    endtask

    task automatic check(input string req, input logic [2:0] exp);
        logic [2:0] act;
        act = {switch_en, shutdown_req, probe_stb};
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: sw/shdn/probe actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic pulse_tick();
        tick_4ms = 1'b1;
        @(negedge clk);
        tick_4ms = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 in reset", 3'b010);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset", 3'b010);

        for (int i = 0; i < NVEC; i++) begin
            set_inputs(VEC[i][12:3]);
            @(negedge clk);
            check($sformatf("R10 table vector %0d", i), VEC[i][2:0]);
        end

        // R12: a tick in normal mode changes nothing
        pulse_tick();
        check("R12 tick in normal", 3'b100);

        // R13: one-edge latency on a trip
        overcurrent = 1'b1;
        #1 check("R13 before edge", 3'b100);
        @(negedge clk);
        overcurrent = 1'b0;
        check("R13 after edge", 3'b000);
        load_clear = 1'b1;
        @(negedge clk);
        load_clear = 1'b0;
        check("R7 clear", 3'b100);

        // R5 7/8 duty across a full wrap
        set_inputs(10'b1000000100);
        @(negedge clk);
        check("R5 slot 0", 3'b100);
        for (int k = 1; k <= 8; k++) begin
            pulse_tick();
            check($sformatf("R5 R11 R12 slot %0d", k % 8),
                  ((k % 8) == 7) ? 3'b001 : 3'b100);
        end
        for (int k = 1; k <= 3; k++) pulse_tick();
        check("R5 slot 3", 3'b100);

        // R11: mode change resets slot; slot 0 in 1/8 is on
        set_inputs(10'b1000010100);
        @(negedge clk);
        check("R11 slot reset on mode change", 3'b100);
        for (int k = 1; k <= 8; k++) begin
            pulse_tick();
            check($sformatf("R6 R12 slot %0d", k % 8),
                  ((k % 8) == 0) ? 3'b100 : 3'b001);
        end

        // charger lost during the probe: shutdown
        pulse_tick();
        check("R6 off slot", 3'b001);
        set_inputs(10'b0000010000);
        @(negedge clk);
        check("R4 charger gone", 3'b010);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule